// File: doc/BRIEF.md
# Timer Capture/Compare Channel Pair

This block has two timer channels. Both watch one free-running 16-bit count, which enters the block as an input. Software sets each channel, through its own control byte, to one of four uses. A channel can leave its pin to general-purpose I/O and preset the level it will start from. It can record the count when a chosen pin transition arrives. It can change its pin when the count reaches a programmed value. Channel 0 can also run a double-buffered compare stream, and in that case it takes over channel 1's value register as its second buffer.

A CPU reaches the block through an 8-bit register port with read and write strobes and a 3-bit address. Each channel has an event flag. Software acknowledges the flag with a two-step handshake, and an event that arrives during the handshake cancels the clear, so a request is never dropped. Each channel drives its pin value, an output enable and an interrupt request. All of these outputs are registered.

Top module: `tccp_pair`

## Requirements
- R1: After reset, every control byte and value register reads 0, and every interrupt request and output enable is low.
- R2: Address bit 2 selects the channel. Address bits 1:0 select the field: 0 is the control byte, 1 is the value high byte, 2 is the value low byte. Read data appears on the cycle after the read strobe. In the control byte, bit 7 is the flag, bit 6 is the interrupt enable, bit 5 is the buffered-mode bit (channel 0 only; it reads 0 on channel 1), bit 4 is the mode bit, and bits 3:2 are the level code. Bits 1:0 read 0.
- R3: A channel is in compare mode when its level code is nonzero and its mode bit is 1. When the count becomes equal to the channel's value, the flag sets, and on the next clock the pin acts according to the level code: 01 toggles, 10 drives low, 11 drives high. A count that stays equal gives only one event.
- R4: A channel is in capture mode when its level code is nonzero and its mode bit is 0. The pin passes through a 2-flop synchronizer. A rising transition (code 01), a falling transition (code 10) or either transition (code 11) copies the count into the value register and sets the flag.
- R5: The flag clears when a read of the control byte sees the flag at 1 and is followed by a write of the control byte with bit 7 at 0.
- R6: Writing 1 to bit 7 never sets the flag. Writing 0 to bit 7 without a prior read that saw the flag set leaves the flag set.
- R7: If a channel event occurs after the arming read and before the write of 0, the write leaves the flag set.
- R8: The interrupt request is the flag ANDed with the interrupt enable, registered one clock later.
- R9: With level code 00, the output enable is low and the pin level is the inverse of the mode bit (mode 1 gives low, mode 0 gives high).
- R10: The output enable is high only in compare mode. It is low in capture mode.
- R11: In buffered mode (channel 0, bit 5 set, level code nonzero), channel 0 compares against its own value first, then against channel 1's value, and alternates after each compare event. A value written to the idle buffer takes effect only once the current compare has fired.
- R12: While buffered mode is on, channel 1's control byte is held cleared. It reads 0, ignores writes, and channel 1's output enable and interrupt request stay low. Channel 1's value bytes remain writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rd_i | input | 1 | Register read strobe |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| cnt_i | input | 16 | Shared timer count |
| pin_i | input | 2 | Channel pin inputs (asynchronous) |
| pin_o | output | 2 | Channel pin output levels |
| pin_oe_o | output | 2 | Channel pin output enables |
| irq_o | output | 2 | Channel interrupt requests |

## Verification
The bench builds the block with its default parameters: a 16-bit count and a 2-stage pin synchronizer. With the full 16-bit width, random compare values can land anywhere in the count range while every byte of the value registers is still exercised. With the short synchronizer, a capture completes in three clocks, so the bench can drive capture edges at fixed points. It can also force an event into the gap between the arming read and the clearing write, which is the race that R7 guards.

// File: rtl/tccp_pkg.sv
package tccp_pkg;
  localparam int TCCP_CNT_W  = 16;
  localparam int TCCP_ADDR_W = 3;
  localparam int TCCP_NCH    = 2;

  localparam logic [1:0] LVL_OFF  = 2'b00;
  localparam logic [1:0] ACT_TOGL = 2'b01;
  localparam logic [1:0] ACT_LOW  = 2'b10;
  localparam logic [1:0] ACT_HIGH = 2'b11;

  localparam logic [1:0] FLD_CTL = 2'd0;
  localparam logic [1:0] FLD_HI  = 2'd1;
  localparam logic [1:0] FLD_LO  = 2'd2;

  typedef struct packed {
    logic       flag;
    logic       ie;
    logic       buf_en;
    logic       mode_a;
    logic [1:0] lvl_sel;
    logic [1:0] rsvd;
  } tccp_ctl_t;
endpackage

// File: rtl/tccp_sync.sv
module tccp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) sh_q <= '0;
    else       sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/tccp_chan.sv
module tccp_chan
  import tccp_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_BUF     = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             ctl_wr_i,
  input  logic             ctl_rd_i,
  input  logic [7:0]       wdata_i,
  input  logic             pin_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_val_i,
  output tccp_ctl_t        ctl_o,
  output logic             cap_o,
  output logic             cmp_o,
  output logic             pin_o,
  output logic             oe_o,
  output logic             irq_o
);
  tccp_ctl_t ctl_q;
  logic arm_q, match_q, pin_q, oe_q, irq_q, prev_q;
  logic pin_s, connected, out_mode, in_mode;
  logic rise, fall, cap_evt, cmp_evt, evt, match;
  logic unused_bits;

  assign unused_bits = ^wdata_i[1:0];

  tccp_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_i(rst_i), .d_i(pin_i), .q_o(pin_s)
  );

  assign connected = (ctl_q.lvl_sel != LVL_OFF);
  assign out_mode  = connected & (ctl_q.mode_a | ctl_q.buf_en);
  assign in_mode   = connected & ~ctl_q.mode_a & ~ctl_q.buf_en;
  assign rise      = pin_s & ~prev_q;
  assign fall      = ~pin_s & prev_q;
  assign cap_evt   = in_mode & ((ctl_q.lvl_sel[0] & rise) | (ctl_q.lvl_sel[1] & fall));
  assign match     = (cnt_i == cmp_val_i);
  assign cmp_evt   = out_mode & match & ~match_q;
  assign evt       = cap_evt | cmp_evt;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      ctl_q <= '0;
      arm_q <= 1'b0;
    end else begin
      if (ctl_wr_i) begin
        ctl_q.ie      <= wdata_i[6];
        ctl_q.buf_en  <= HAS_BUF ? wdata_i[5] : 1'b0;
        ctl_q.mode_a  <= wdata_i[4];
        ctl_q.lvl_sel <= wdata_i[3:2];
      end
      if (evt)                                  ctl_q.flag <= 1'b1;
      else if (ctl_wr_i && arm_q && !wdata_i[7]) ctl_q.flag <= 1'b0;
      if (evt || ctl_wr_i)              arm_q <= 1'b0;
      else if (ctl_rd_i && ctl_q.flag)  arm_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      prev_q  <= 1'b0;
      match_q <= 1'b0;
      pin_q   <= 1'b1;
      oe_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= pin_s;
      match_q <= match;
      oe_q    <= out_mode;
      irq_q   <= ctl_q.flag & ctl_q.ie;
      if (!connected) pin_q <= ~ctl_q.mode_a;
      else if (cmp_evt) begin
        case (ctl_q.lvl_sel)
          ACT_TOGL: pin_q <= ~pin_q;
          ACT_LOW:  pin_q <= 1'b0;
          default:  pin_q <= 1'b1;
        endcase
      end
    end
  end

  assign ctl_o = ctl_q;
  assign cap_o = cap_evt;
  assign cmp_o = cmp_evt;
  assign pin_o = pin_q;
  assign oe_o  = oe_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tccp_pair.sv
module tccp_pair
  import tccp_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_i,
  input  logic                   rd_i,
  input  logic                   wr_i,
  input  logic [TCCP_ADDR_W-1:0] addr_i,
  input  logic [7:0]             wdata_i,
  output logic [7:0]             rdata_o,
  input  logic [TCCP_CNT_W-1:0]  cnt_i,
  input  logic [TCCP_NCH-1:0]    pin_i,
  output logic [TCCP_NCH-1:0]    pin_o,
  output logic [TCCP_NCH-1:0]    pin_oe_o,
  output logic [TCCP_NCH-1:0]    irq_o
);
  localparam int CW = TCCP_CNT_W;

  tccp_ctl_t        ctl_w [TCCP_NCH];
  logic             cap_w [TCCP_NCH];
  logic             cmp_w [TCCP_NCH];
  logic [CW-1:0]    val_q [TCCP_NCH];
  logic [CW-1:0]    cmpv_w[TCCP_NCH];
  logic             en_w  [TCCP_NCH];
  logic             ch;
  logic [1:0]       fld;
  logic             buf_on, sel_q;
  logic [7:0]       rdata_q;

  assign ch     = addr_i[2];
  assign fld    = addr_i[1:0];
  assign buf_on = ctl_w[0].buf_en;

  always_ff @(posedge clk_i) begin
    if (rst_i || !buf_on) sel_q <= 1'b0;
    else if (cmp_w[0])    sel_q <= ~sel_q;
  end

  assign cmpv_w[0] = (buf_on && sel_q) ? val_q[1] : val_q[0];
  assign cmpv_w[1] = val_q[1];
  assign en_w[0]   = 1'b1;
  assign en_w[1]   = ~buf_on;

  for (genvar c = 0; c < TCCP_NCH; c++) begin : g_ch
    logic hit;
    assign hit = (ch == c[0]);

    always_ff @(posedge clk_i) begin
      if (rst_i)                             val_q[c] <= '0;
      else if (cap_w[c])                     val_q[c] <= cnt_i;
      else if (wr_i && hit && fld == FLD_HI) val_q[c][CW-1:8] <= wdata_i;
      else if (wr_i && hit && fld == FLD_LO) val_q[c][7:0] <= wdata_i;
    end

    tccp_chan #(
      .CNT_W(CW), .SYNC_STAGES(SYNC_STAGES), .HAS_BUF(c == 0)
    ) u_chan (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .en_i     (en_w[c]),
      .ctl_wr_i (wr_i && hit && fld == FLD_CTL),
      .ctl_rd_i (rd_i && hit && fld == FLD_CTL),
      .wdata_i  (wdata_i),
      .pin_i    (pin_i[c]),
      .cnt_i    (cnt_i),
      .cmp_val_i(cmpv_w[c]),
      .ctl_o    (ctl_w[c]),
      .cap_o    (cap_w[c]),
      .cmp_o    (cmp_w[c]),
      .pin_o    (pin_o[c]),
      .oe_o     (pin_oe_o[c]),
      .irq_o    (irq_o[c])
    );
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) rdata_q <= '0;
    else if (rd_i) begin
      case (fld)
        FLD_CTL: rdata_q <= (ch && buf_on) ? 8'h00 : ctl_w[ch];
        FLD_HI:  rdata_q <= val_q[ch][CW-1:8];
        FLD_LO:  rdata_q <= val_q[ch][7:0];
        default: rdata_q <= 8'h00;
      endcase
    end
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/tccp_pair_chk.sv
module tccp_pair_chk (
  input logic       clk_i,
  input logic       rst_i,
  input logic       wr_i,
  input logic [2:0] addr_i,
  input logic [7:0] wdata_i,
  input logic [1:0] irq_o,
  input logic [1:0] pin_oe_o,
  input logic [7:0] ctl0_i,
  input logic [7:0] ctl1_i,
  input logic       cap0_i,
  input logic       cmp0_i,
  input logic       cap1_i,
  input logic       cmp1_i
);
  AST_FLAG0_RISE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ctl0_i[7]) |-> $past(cap0_i || cmp0_i)); // R6
  AST_FLAG1_RISE_NEEDS_EVENT: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(ctl1_i[7]) |-> $past(cap1_i || cmp1_i)); // R6
  AST_FLAG0_FALL_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(ctl0_i[7]) |-> $past(wr_i && addr_i == 3'd0 && !wdata_i[7])); // R5
  AST_CAPTURE_SETS_FLAG: assert property (@(posedge clk_i) disable iff (rst_i)
    cap0_i |=> ctl0_i[7]); // R4
  AST_IRQ0_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o[0] |-> $past(ctl0_i[6] && ctl0_i[7])); // R8
  AST_IRQ1_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_o[1] |-> $past(ctl1_i[6] && ctl1_i[7])); // R8
  AST_OE0_NEEDS_LEVEL: assert property (@(posedge clk_i) disable iff (rst_i)
    pin_oe_o[0] |-> $past(ctl0_i[3:2] != 2'b00)); // R10
  AST_CH1_QUIET_IN_BUF: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(ctl0_i[5]) && $past(ctl0_i[5], 2)) |-> (!pin_oe_o[1] && !irq_o[1])); // R12
endmodule

bind tccp_pair tccp_pair_chk u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .wr_i    (wr_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .irq_o   (irq_o),
  .pin_oe_o(pin_oe_o),
  .ctl0_i  (ctl_w[0]),
  .ctl1_i  (ctl_w[1]),
  .cap0_i  (cap_w[0]),
  .cmp0_i  (cmp_w[0]),
  .cap1_i  (cap_w[1]),
  .cmp1_i  (cmp_w[1])
);

// File: tb/tccp_pair_tb.sv
`timescale 1ns/1ps
module tccp_pair_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] cnt = '0;
  logic [1:0]  pin_in = '0;
  logic [1:0]  pin_out, pin_oe, irq;
  int n_cmp = 0, n_bad = 0;
  logic [7:0] rv;
  logic exp_pin;

  always #2.5 clk = ~clk;

  tccp_pair u_dut (
    .clk_i(clk), .rst_i(rst), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .cnt_i(cnt), .pin_i(pin_in),
    .pin_o(pin_out), .pin_oe_o(pin_oe), .irq_o(irq)
  );

  function automatic logic act_fn(input logic [1:0] code, input logic cur);
    case (code)
      2'b01:   return ~cur;
      2'b10:   return 1'b0;
      2'b11:   return 1'b1;
      default: return cur;
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0; d = rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cnt(input logic [15:0] v);
    @(negedge clk); cnt = v;
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    wait_n(2);
    // R1 reset state
    bus_rd(3'd0, rv); chk("R1 ctl0", rv, 8'h00);
    bus_rd(3'd4, rv); chk("R1 ctl1", rv, 8'h00);
    bus_rd(3'd5, rv); chk("R1 val1 hi", rv, 8'h00);
    chk("R1 irq", irq, 2'b00);
    chk("R1 oe", pin_oe, 2'b00);
    // R9 disconnected level
    chk("R9 default high", pin_out[0], 1'b1);
    bus_wr(3'd0, 8'h10); wait_n(2);
    chk("R9 mode1 low", pin_out[0], 1'b0);
    chk("R9 oe low", pin_oe[0], 1'b0);
    bus_wr(3'd0, 8'h00); wait_n(2);
    chk("R9 mode0 high", pin_out[0], 1'b1);
    // R3 compare, toggle
    bus_wr(3'd1, 8'h01); bus_wr(3'd2, 8'h00);
    bus_wr(3'd0, 8'h57); wait_n(2);
    bus_rd(3'd0, rv); chk("R2 rsvd bits and bit5", rv, 8'h54);
    chk("R10 oe compare", pin_oe[0], 1'b1);
    chk("R3 pin before match", pin_out[0], 1'b1);
    set_cnt(16'h0100); wait_n(3);
    chk("R3 toggle", pin_out[0], 1'b0);
    chk("R8 irq set", irq[0], 1'b1);
    wait_n(3);
    chk("R3 single event while equal", pin_out[0], 1'b0);
    // R5 clear sequence
    bus_rd(3'd0, rv); chk("R3 flag", rv, 8'hD4);
    bus_wr(3'd0, 8'h54); wait_n(2);
    bus_rd(3'd0, rv); chk("R5 cleared", rv, 8'h54);
    chk("R8 irq clear", irq[0], 1'b0);
    // R6 write 1 does not set
    bus_wr(3'd0, 8'hD4);
    bus_rd(3'd0, rv); chk("R6 w1 no set", rv, 8'h54);
    // R6 write 0 without read
    set_cnt(16'h0101); wait_n(2); set_cnt(16'h0100); wait_n(3);
    chk("R3 toggle again", pin_out[0], 1'b1);
    bus_wr(3'd0, 8'h54);
    bus_rd(3'd0, rv); chk("R6 no read no clear", rv, 8'hD4);
    // R7 event between read and write
    set_cnt(16'h0101); wait_n(2); set_cnt(16'h0100); wait_n(3);
    bus_wr(3'd0, 8'h54);
    bus_rd(3'd0, rv); chk("R7 race keeps flag", rv, 8'hD4);
    bus_wr(3'd0, 8'h54);
    bus_rd(3'd0, rv); chk("R5 clear after read", rv, 8'h54);
    // R4 capture on channel 1
    bus_wr(3'd4, 8'h44);
    set_cnt(16'h1234);
    @(negedge clk); pin_in[1] = 1'b1; wait_n(5);
    chk("R10 oe capture", pin_oe[1], 1'b0);
    chk("R8 irq1", irq[1], 1'b1);
    bus_rd(3'd4, rv); chk("R4 rise flag", rv, 8'hC4);
    bus_rd(3'd5, rv); chk("R4 cap hi", rv, 8'h12);
    bus_rd(3'd6, rv); chk("R4 cap lo", rv, 8'h34);
    bus_wr(3'd4, 8'h44);
    set_cnt(16'h5678);
    @(negedge clk); pin_in[1] = 1'b0; wait_n(5);
    bus_rd(3'd4, rv); chk("R4 fall ignored", rv, 8'h44);
    bus_rd(3'd5, rv); chk("R4 value kept", rv, 8'h12);
    bus_wr(3'd4, 8'h4C);
    @(negedge clk); pin_in[1] = 1'b1; wait_n(5);
    bus_rd(3'd5, rv); chk("R4 either edge hi", rv, 8'h56);
    bus_rd(3'd4, rv); chk("R4 either flag", rv, 8'hCC);
    // R3 random compares, channel 0, no interrupt enable
    bus_wr(3'd0, 8'h10); wait_n(2);
    exp_pin = 1'b0;
    for (int i = 0; i < 24; i++) begin
      logic [15:0] v;
      logic [1:0] code;
      v = 16'($urandom);
      code = 2'($urandom_range(1, 3));
      set_cnt(v ^ 16'h8000);
      bus_wr(3'd1, v[15:8]); bus_wr(3'd2, v[7:0]);
      bus_wr(3'd0, {4'h1, code, 2'b00}); wait_n(2);
      set_cnt(v); wait_n(3);
      exp_pin = act_fn(code, exp_pin);
      chk("R3 random action", pin_out[0], exp_pin);
    end
    chk("R8 ie off no irq", irq[0], 1'b0);
    bus_rd(3'd0, rv); chk("R8 flag set under ie off", rv[7], 1'b1);
    // R11/R12 buffered mode
    set_cnt(16'h0000);
    bus_wr(3'd0, 8'h00); wait_n(2);
    bus_wr(3'd1, 8'h00); bus_wr(3'd2, 8'h10);
    bus_wr(3'd5, 8'h00); bus_wr(3'd6, 8'h20);
    bus_wr(3'd0, 8'h34); wait_n(3);
    bus_rd(3'd4, rv); chk("R12 ch1 ctl reads 0", rv, 8'h00);
    bus_wr(3'd4, 8'h54);
    bus_rd(3'd4, rv); chk("R12 ch1 write ignored", rv, 8'h00);
    chk("R12 ch1 oe low", pin_oe[1], 1'b0);
    chk("R12 ch1 irq low", irq[1], 1'b0);
    chk("R11 oe ch0", pin_oe[0], 1'b1);
    set_cnt(16'h0010); wait_n(3);
    chk("R11 first buffer", pin_out[0], 1'b0);
    set_cnt(16'h0011); wait_n(2); set_cnt(16'h0010); wait_n(3);
    chk("R11 first buffer idle", pin_out[0], 1'b0);
    set_cnt(16'h0020); wait_n(3);
    chk("R11 second buffer", pin_out[0], 1'b1);
    set_cnt(16'h0010); wait_n(3);
    chk("R11 back to first", pin_out[0], 1'b0);
    bus_wr(3'd6, 8'h30);
    bus_rd(3'd6, rv); chk("R12 ch1 value writable", rv, 8'h30);
    set_cnt(16'h0020); wait_n(3);
    chk("R11 old value dropped", pin_out[0], 1'b0);
    set_cnt(16'h0030); wait_n(3);
    chk("R11 new value used", pin_out[0], 1'b1);
    summary();
  end
endmodule